// File: doc/BRIEF.md
# Failure and Status Interrupt Aggregator

This block gathers interrupt sources of two kinds and hands one combined request to a downstream interrupt concentrator. The first kind is a set of backplane failure lines. Each line is active low, so it is asserted while it is 0. The block brings each line into the clock domain and watches it for a deassertion, which is a 0-to-1 transition. Every such transition sets a sticky pending bit. Software clears that bit by writing 1 to it. The second kind is a set of level flags owned by other blocks. The pending register only mirrors these flags. They are cleared in their own blocks, and no write here affects them.

An enable register masks each source one by one. The request output is registered. It is high whenever some source is both pending and enabled. Software reaches both registers through a simple word-addressed read/write port. The pending register is at word 0 and the enable register at word 1. Reads return data one cycle after the read strobe. The block does not prioritize sources and does not produce vectors.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, the failure pending bits, the enable register and `irq_o` are all 0.
- R2: A 0-to-1 transition on `fail_line_i[i]` sets pending bit i of word 0. The bit is set on the third rising clock edge after the change. With the bit enabled, `irq_o` rises on the fourth edge.
- R3: Writing 1 to bit i (i < N_FAIL) of word 0 clears failure pending bit i. Writing 0 to that bit leaves it unchanged.
- R4: Bits N_FAIL+j of word 0 read `src_flag_i[j]` as its current value. Writes to word 0 never change these bits.
- R5: If a deassertion transition is latched on the same edge as a write-1 clear of that bit, the bit remains set.
- R6: Word 1 is the enable register. Bit k enables source k, which is pending bit k of word 0. It reads back what was written, and bits N_FAIL+N_LVL and above read 0.
- R7: `irq_o` is 1 in the cycle after an edge where some pending bit and its enable bit were both 1. Otherwise it is 0.
- R8: A 1-to-0 transition (assertion) on a failure line does not set its pending bit.
- R9: Words 2 and 3 read as 0, and writes to them change neither register.
- R10: A failure line that stays at 1 through the release of reset produces no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fail_line_i | input | N_FAIL | Asynchronous failure lines, active low |
| src_flag_i | input | N_LVL | Level interrupt flags from owning blocks |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Two actions can fall on the same clock edge: a failure line's deassertion being latched into its pending bit, and a software write-1 that clears the same bit. The bench raises the line at a known cycle and then places the clearing write exactly on the edge that latches the transition. It also places the write one edge earlier and one edge later. After each case it reads word 0. The bit must still be set when the write came earlier or on the same edge, and must be clear only when the write came after the latch.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register word offsets
    localparam int unsigned PEND_WORD = 0;
    localparam int unsigned EN_WORD   = 1;

    // Register selected by a bus access
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;

    // Decoded bus request
    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } bus_req_t;

    function automatic reg_sel_e decode_word(input int unsigned word);
        if (word == PEND_WORD) return SEL_PEND;
        if (word == EN_WORD)   return SEL_EN;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/fail_edge_latch.sv
module fail_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic clr_i,
    output logic pend_o
);
    // sync chain plus one history flop; idle level is the deasserted 1
    logic [SYNC_STAGES:0] chain_q;
    logic                 rise;
    logic                 pend_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], line_i};
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q & ~clr_i) | rise;
    end

    assign pend_o = pend_q;

    // R2 / R5: a latched transition always leaves the bit set
    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend_q);
    // R3: a set bit only drops through a clear
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);
    // R8: a clear bit only rises on a deassertion transition
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !rise) |=> !pend_q);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_agg_pkg::*;
#(
    parameter int N_FAIL = 2,
    parameter int N_LVL  = 6,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [N_FAIL-1:0]          pend_fail_i,
    input  logic [N_LVL-1:0]           src_flag_i,
    output logic [N_FAIL-1:0]          clr_fail_o,
    output logic [N_FAIL+N_LVL-1:0]    pend_all_o,
    output logic [N_FAIL+N_LVL-1:0]    en_o,
    output logic [DATA_W-1:0]          bus_rdata
);
    localparam int N_SRC = N_FAIL + N_LVL;

    bus_req_t                req;
    logic [N_SRC-1:0]        en_q;
    logic [DATA_W-1:0]       rd_mux;
    logic [DATA_W-1:0]       rdata_q;
    logic                    unused_wdata_hi;

    always_comb begin
        req.sel = decode_word(int'(bus_addr));
        req.wr  = bus_wr;
        req.rd  = bus_rd;
    end

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_SRC];
    assign pend_all_o      = {src_flag_i, pend_fail_i};
    assign clr_fail_o      = (req.wr && req.sel == SEL_PEND) ? bus_wdata[N_FAIL-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)                              en_q <= '0;
        else if (req.wr && req.sel == SEL_EN) en_q <= bus_wdata[N_SRC-1:0];
    end

    always_comb begin
        rd_mux = '0;
        case (req.sel)
            SEL_PEND: rd_mux[N_SRC-1:0] = pend_all_o;
            SEL_EN:   rd_mux[N_SRC-1:0] = en_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_mux;
    end

    assign en_o      = en_q;
    assign bus_rdata = rdata_q;

    // R6: enable write lands one edge later
    assert_en_write_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && req.sel == SEL_EN) |=> en_q == $past(bus_wdata[N_SRC-1:0]));
    // R9: unmapped words read zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && req.sel == SEL_NONE) |=> bus_rdata == '0);
    // R4: mirrored bits show the source flags at the read
    assert_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && req.sel == SEL_PEND) |=> bus_rdata[N_SRC-1:N_FAIL] == $past(src_flag_i));
    // R9: enable untouched by writes elsewhere
    assert_en_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && req.sel == SEL_EN) |=> $stable(en_q));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_i & en_i);
    end

    assign irq_o = irq_q;

    // R7: request follows enabled pending sources by one edge
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_i) != '0) |=> irq_o);
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_i) == '0) |=> !irq_o);
    // R1: reset clears the request
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !irq_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int N_FAIL      = 2,
    parameter int N_LVL       = 6,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FAIL-1:0] fail_line_i,
    input  logic [N_LVL-1:0]  src_flag_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int N_SRC = N_FAIL + N_LVL;

    logic [N_FAIL-1:0] pend_fail;
    logic [N_FAIL-1:0] clr_fail;
    logic [N_SRC-1:0]  pend_all;
    logic [N_SRC-1:0]  en;

    for (genvar i = 0; i < N_FAIL; i++) begin : g_fail
        fail_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
            .clk    (clk),
            .rst    (rst),
            .line_i (fail_line_i[i]),
            .clr_i  (clr_fail[i]),
            .pend_o (pend_fail[i])
        );
    end

    irq_regs #(
        .N_FAIL (N_FAIL),
        .N_LVL  (N_LVL),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .pend_fail_i (pend_fail),
        .src_flag_i  (src_flag_i),
        .clr_fail_o  (clr_fail),
        .pend_all_o  (pend_all),
        .en_o        (en),
        .bus_rdata   (bus_rdata)
    );

    irq_merge #(.N_SRC(N_SRC)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend_all),
        .en_i   (en),
        .irq_o  (irq_o)
    );
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  fail_line_i;
    logic [5:0]  src_flag_i;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst(rst), .fail_line_i(fail_line_i), .src_flag_i(src_flag_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // raise a line from low after it has settled low
    task automatic pulse_low(input int idx);
        @(negedge clk);
        fail_line_i[idx] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        fail_line_i[idx] = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // raise line 0 and land a write-1 clear on latch edge + offset
    task automatic race(input int offset, output logic [31:0] d);
        @(negedge clk);
        fail_line_i[0] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        fail_line_i[0] = 1'b1;
        repeat (2 + offset) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(posedge clk);
        rd(2'd0, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; fail_line_i = 2'b11; src_flag_i = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        repeat (4) @(posedge clk);
        rd(2'd0, d); chk("R1 R10 pending", d, 32'h0);
        rd(2'd1, d); chk("R1 enable", d, 32'h0);

        // R8: assertion alone sets nothing
        @(negedge clk); fail_line_i[1] = 1'b0;
        repeat (5) @(posedge clk);
        rd(2'd0, d); chk("R8 assert edge", d, 32'h0);
        @(negedge clk); fail_line_i[1] = 1'b1;
        repeat (4) @(posedge clk);
        rd(2'd0, d); chk("R2 line1 set", d, 32'h2);

        // R2 exact latency on line 0 via irq
        wr(2'd1, 32'h1);
        @(negedge clk); fail_line_i[0] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); fail_line_i[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R2 irq before", {31'b0, irq_o}, 32'h0);
        @(posedge clk);
        @(negedge clk); chk("R2 irq after", {31'b0, irq_o}, 32'h1);
        rd(2'd0, d); chk("R2 both set", d, 32'h3);

        // R3: write 0 no effect, write 1 clears only that bit
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R3 write0", d, 32'h3);
        wr(2'd0, 32'h1);
        rd(2'd0, d); chk("R3 clear bit0", d, 32'h2);
        chk("R7 irq dropped", {31'b0, irq_o}, 32'h0);

        // R9: unmapped words
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, d); chk("R9 word2", d, 32'h0);
        rd(2'd3, d); chk("R9 word3", d, 32'h0);
        rd(2'd0, d); chk("R9 pending kept", d, 32'h2);
        rd(2'd1, d); chk("R9 enable kept", d, 32'h1);

        // R4: mirror and write immunity
        @(negedge clk); src_flag_i = 6'b101101;
        rd(2'd0, d); chk("R4 mirror", d, {24'b0, 6'b101101, 2'b10});
        wr(2'd0, 32'hFFFF_FFFC);
        rd(2'd0, d); chk("R4 write ignored", d, {24'b0, 6'b101101, 2'b10});
        @(negedge clk); src_flag_i = 6'b010010;
        rd(2'd0, d); chk("R4 mirror2", d, {24'b0, 6'b010010, 2'b10});

        // R5: clear one edge early, on the latch edge, one edge late
        wr(2'd0, 32'h3);
        race(-1, d); chk("R5 clear before latch", d[0], 1'b1);
        wr(2'd0, 32'h1);
        race(0, d);  chk("R5 clear on latch edge", d[0], 1'b1);
        wr(2'd0, 32'h1);
        race(1, d);  chk("R3 clear after latch", d[0], 1'b0);

        // R6/R7 sweep: pending = {flags, 2'b10}
        pulse_low(1);
        for (int e = 0; e < 256; e++) begin
            logic [5:0] fl;
            logic [7:0] pend;
            fl = 6'((e * 37 + 11) & 63);
            pend = {fl, 2'b10};
            @(negedge clk); src_flag_i = fl;
            wr(2'd1, {24'hA5A5A5, 8'(e)});
            @(negedge clk);
            chk("R7 irq sweep", {31'b0, irq_o}, {31'b0, |(pend & 8'(e))});
            rd(2'd1, d);
            chk("R6 enable readback", d, {24'b0, 8'(e)});
        end

        // R1: reset mid-run clears state
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0; src_flag_i = '0;
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        rd(2'd0, d); chk("R1 pending after reset", d, 32'h0);
        rd(2'd1, d); chk("R1 enable after reset", d, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule